// File: doc/BRIEF.md
# Nibble-Table Constant Multiplier

This block multiplies an unsigned 8-bit operand by an 8-bit constant that can be reloaded while the chip runs. It does not use a shift-and-add array. The operand is cut into a high and a low 4-bit half, and each half indexes its own 16-entry table of precomputed multiples of the constant. Both tables hold the same 12-bit words, where entry n holds n times the constant.

The high-half word carries a weight of sixteen against the low-half word. The low four bits of the low-half word therefore have nothing to be added to. They go straight to the bottom of the result. One 12-bit adder sums the full high word with the upper eight bits of the low word.

Software programs the tables in one of two ways:
- **Host writes.** Each host write stores one word at the same address in both tables.
- **Automatic fill.** A load request captures a new constant and writes all sixteen multiples, one per cycle. It holds `busy` high while it does so.

Table reads are registered. A result therefore appears one cycle after its operand and is flagged by `outValid`.

Top module: `kmult_top`

## Requirements
- R1: Reset clears both tables to zero and drives `busy`, `outValid` and `y` to 0. Any operand multiplied before a table is programmed gives `y` = 0.
- R2: Let `opX` be sampled with `opValid` = 1, with high half H = `opX[7:4]` and low half L = `opX[3:0]`. In the next cycle, `y` equals (16·table[H] + table[L]) mod 65536. Bits [3:0] of `y` are bits [3:0] of table[L]. When the tables hold the multiples of a constant k, `y` = `opX`·k for all 256 operands.
- R3: `outValid` is 1 in exactly the cycle after a clock edge that samples `opValid` = 1, and 0 otherwise. After an edge that samples `opValid` = 0, `y` keeps its previous value.
- R4: While `busy` is 0, an edge sampling `wrEn` = 1 stores `wrData` at `wrAddr` in both tables. A multiply sampled at that same edge still reads the old entry. Only multiplies sampled at later edges see the new word.
- R5: While `busy` is 0, an edge sampling `loadK` = 1 captures `kValue` as k. `busy` then rises in the next cycle and stays high for exactly 16 cycles. Afterwards every entry n (0 to 15) holds n·k.
- R6: While `busy` is 1, `wrEn` and `loadK` are ignored. No host write lands in the tables, and no new fill starts or restarts.
- R7: Table words are 12 bits wide, so the largest multiple of the largest constant fits without loss. With k = 85, entry 15 holds 1275, so operand 0x0F gives `y` = 1275. With k = 255, operand 0xFF gives `y` = 65025.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| loadK | input | 1 | Request to fill both tables with multiples of `kValue` |
| kValue | input | 8 | Constant captured by a fill request |
| wrEn | input | 1 | Host write strobe for one table word |
| wrAddr | input | 4 | Table index of the host write |
| wrData | input | 12 | Word stored by the host write |
| opValid | input | 1 | Operand valid |
| opX | input | 8 | Unsigned operand |
| busy | output | 1 | Automatic fill in progress |
| outValid | output | 1 | `y` holds a fresh product this cycle |
| y | output | 16 | Product |

## Verification
The assertions assume the following about the inputs:
- `rstN` is held low from time zero up to the first edges.
- Every input is at a known level at each rising edge once reset is released.

The bench drives all inputs only on falling clock edges, so each input is settled well before the next rising edge samples it.

Multiplies are allowed during a fill. They read a mix of old and new words. This is legal, and the cycle-accurate reference model follows it exactly. Directed checks that compare against operand times constant are issued only while `busy` is low.

// File: rtl/kmult_pkg.sv
package kmult_pkg;
  localparam int NIB_W   = 4;                 // operand half width
  localparam int K_W     = 8;                 // constant width
  localparam int ENTRIES = 1 << NIB_W;        // table depth
  localparam int PROD_W  = NIB_W + K_W;       // table word width
  localparam int X_W     = 2 * NIB_W;         // operand width
  localparam int Y_W     = PROD_W + NIB_W;    // product width
  localparam int N_TBL   = 2;                 // one table per operand half

  // Write strobes from control to datapath
  typedef struct packed {
    logic              wr;
    logic [NIB_W-1:0]  addr;
    logic [PROD_W-1:0] data;
  } tblWr_t;
endpackage

// File: rtl/kmult_table.sv
module kmult_table
  import kmult_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tblWr_t            wrStb,
  input  logic              rdEn,
  input  logic [NIB_W-1:0]  rdAddr,
  output logic [PROD_W-1:0] rdWord
);
  logic [PROD_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (wrStb.wr) begin
      mem[wrStb.addr] <= wrStb.data;
    end
  end

  // Registered read: a write at the same edge is not yet visible
  always_ff @(posedge clk) begin
    if (!rstN)     rdWord <= '0;
    else if (rdEn) rdWord <= mem[rdAddr];
  end
endmodule

// File: rtl/kmult_ctrl.sv
module kmult_ctrl
  import kmult_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadK,
  input  logic [K_W-1:0]    kValue,
  input  logic              wrEn,
  input  logic [NIB_W-1:0]  wrAddr,
  input  logic [PROD_W-1:0] wrData,
  output logic              busy,
  output tblWr_t            wrStb
);
  localparam logic [NIB_W-1:0] LAST_IDX = NIB_W'(ENTRIES - 1);

  logic [NIB_W-1:0]  fillIdx;
  logic [PROD_W-1:0] fillAcc;
  logic [K_W-1:0]    kReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      fillIdx <= '0;
      fillAcc <= '0;
      kReg    <= '0;
    end else if (busy) begin
      fillIdx <= fillIdx + 1'b1;
      fillAcc <= fillAcc + {{NIB_W{1'b0}}, kReg};
      if (fillIdx == LAST_IDX) busy <= 1'b0;
    end else if (loadK) begin
      busy    <= 1'b1;
      fillIdx <= '0;
      fillAcc <= '0;
      kReg    <= kValue;
    end
  end

  // Fill owns the write port while busy; host writes are dropped then
  always_comb begin
    if (busy) begin
      wrStb.wr   = 1'b1;
      wrStb.addr = fillIdx;
      wrStb.data = fillAcc;
    end else begin
      wrStb.wr   = wrEn;
      wrStb.addr = wrAddr;
      wrStb.data = wrData;
    end
  end

  AST_FILL_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (fillIdx == '0 && fillAcc == '0)); // R5
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && fillIdx != LAST_IDX) |=> (busy && fillIdx == NIB_W'($past(fillIdx) + 1'b1))); // R5
  AST_FILL_END: assert property (@(posedge clk) disable iff (!rstN)
    (busy && fillIdx == LAST_IDX) |=> !busy); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && fillIdx != LAST_IDX) |=> $stable(kReg)); // R6
endmodule

// File: rtl/kmult_datapath.sv
module kmult_datapath
  import kmult_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  tblWr_t         wrStb,
  input  logic           opValid,
  input  logic [X_W-1:0] opX,
  output logic           outValid,
  output logic [Y_W-1:0] y
);
  logic [PROD_W-1:0] rdWord [N_TBL];
  logic [PROD_W-1:0] upperSum;

  // Table 0 is indexed by the low half, table 1 by the high half
  for (genvar g = 0; g < N_TBL; g++) begin : gTbl
    kmult_table uTbl (
      .clk    (clk),
      .rstN   (rstN),
      .wrStb  (wrStb),
      .rdEn   (opValid),
      .rdAddr (opX[g*NIB_W +: NIB_W]),
      .rdWord (rdWord[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= opValid;
  end

  // Reduced adder: the low nibble of the low word has nothing to meet
  assign upperSum = rdWord[1] + {{NIB_W{1'b0}}, rdWord[0][PROD_W-1:NIB_W]};
  assign y        = {upperSum, rdWord[0][NIB_W-1:0]};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> outValid); // R3
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !outValid); // R3
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(y)); // R3
endmodule

// File: rtl/kmult_top.sv
module kmult_top
  import kmult_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadK,
  input  logic [K_W-1:0]    kValue,
  input  logic              wrEn,
  input  logic [NIB_W-1:0]  wrAddr,
  input  logic [PROD_W-1:0] wrData,
  input  logic              opValid,
  input  logic [X_W-1:0]    opX,
  output logic              busy,
  output logic              outValid,
  output logic [Y_W-1:0]    y
);
  tblWr_t wrStb;

  kmult_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .loadK  (loadK),
    .kValue (kValue),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .busy   (busy),
    .wrStb  (wrStb)
  );

  kmult_datapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .opValid  (opValid),
    .opX      (opX),
    .outValid (outValid),
    .y        (y)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!busy && !outValid && y == '0)); // R1
endmodule

// File: tb/tb_kmult_top.sv
`timescale 1ns/1ps
module tb_kmult_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadK = 1'b0;
  logic [7:0]  kValue = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic        opValid = 1'b0;
  logic [7:0]  opX = '0;
  logic        busy, outValid;
  logic [15:0] y;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  kmult_top dut (
    .clk(clk), .rstN(rstN), .loadK(loadK), .kValue(kValue),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .opValid(opValid), .opX(opX),
    .busy(busy), .outValid(outValid), .y(y)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: one shared table, a fill counter, a result register
  int mTbl [16];
  int mY = 0, mValid = 0, mBusy = 0, mIdx = 0, mK = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mTbl[i]) mTbl[i] = 0;
      mY = 0; mValid = 0; mBusy = 0; mIdx = 0; mK = 0;
    end else begin
      if (opValid) mY = (mTbl[opX / 16] * 16 + mTbl[opX % 16]) % 65536;
      mValid = opValid;
      if (mBusy != 0) begin
        mTbl[mIdx] = (mIdx * mK) % 4096;
        if (mIdx == 15) mBusy = 0;
        else mIdx++;
      end else begin
        if (wrEn) mTbl[wrAddr] = wrData;
        if (loadK) begin mBusy = 1; mIdx = 0; mK = kValue; end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk(y == mY[15:0],             "R2 y vs model",        y,        mY);
      chk(outValid == (mValid != 0), "R3 outValid vs model", outValid, mValid);
      chk(busy == (mBusy != 0),      "R5 busy vs model",     busy,     mBusy);
    end
  end

  task automatic loadConst(input int k, input bit disturb);
    int n;
    @(negedge clk); loadK = 1'b1; kValue = 8'(k);
    @(negedge clk); loadK = 1'b0;
    chk(busy == 1'b1, "R5 busy rises after request", busy, 1);
    if (disturb) begin
      // R6: host write and second request while busy must be ignored
      wrEn = 1'b1; wrAddr = 4'd5; wrData = 12'hFFF; loadK = 1'b1; kValue = 8'd200;
      @(negedge clk);
      wrEn = 1'b0; loadK = 1'b0;
      n = 1;
    end else n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 16, "R5 busy length", n, 16);
  endtask

  task automatic sweep(input int k);
    for (int i = 0; i <= 256; i++) begin
      @(negedge clk);
      if (i > 0) chk(y == 16'((i - 1) * k), "R2 y == x*k sweep", y, (i - 1) * k);
      if (i < 256) begin opValid = 1'b1; opX = 8'(i); end
      else opValid = 1'b0;
    end
  endtask

  task automatic mulOne(input int x, input int exp, input string req);
    @(negedge clk); opValid = 1'b1; opX = 8'(x);
    @(negedge clk); opValid = 1'b0;
    chk(y == 16'(exp), req, y, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && outValid == 1'b0 && y == 16'd0, "R1 reset outputs", y, 0);
    rstN = 1'b1;
    mulOne(8'hFF, 0, "R1 empty tables give zero");
    mulOne(8'h5A, 0, "R1 empty tables give zero");

    loadConst(85, 1'b0);
    mulOne(8'h0F, 1275, "R7 entry 15 of k=85");
    sweep(85);

    // R3: idle after a result, output held and not flagged
    mulOne(8'h23, 35 * 85, "R3 single op");
    @(negedge clk);
    chk(outValid == 1'b0, "R3 outValid idle", outValid, 0);
    chk(y == 16'(35 * 85), "R3 y held", y, 35 * 85);

    // R4: write at same edge as a read; old word seen, then new word
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd3; wrData = 12'd100; opValid = 1'b1; opX = 8'h33;
    @(negedge clk);
    wrEn = 1'b0; opValid = 1'b0;
    chk(y == 16'(51 * 85), "R4 same-edge read sees old word", y, 51 * 85);
    mulOne(8'h33, 1700, "R4 later read sees new word");
    mulOne(8'h03, 100,  "R4 low-table copy written");

    loadConst(0, 1'b0);   sweep(0);
    loadConst(1, 1'b0);   sweep(1);
    loadConst(255, 1'b0);
    mulOne(8'hFF, 65025, "R7 largest product");
    sweep(255);

    loadConst(37, 1'b1);
    mulOne(8'h05, 5 * 37,  "R6 host write during fill dropped");
    mulOne(8'h11, 17 * 37, "R6 second request ignored");
    sweep(37);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule